// File: doc/BRIEF.md
# Character Display Parallel Host Port

This block is the host-side front end of a character display controller. A microcontroller drives a register-select line, a read/write line, an enable strobe and an eight-line data bus. The block brings those asynchronous pins into the core clock domain and decides what each transfer means. Register-select low with write loads an instruction. Register-select low with read returns a status byte, which is the core's busy bit above its 7-bit address counter. Register-select high reaches the data register in both directions.

A transfer opens when enable rises and is committed when enable falls. The core sees single-cycle strobes: instruction write, data write, and data read-done. Read-done follows a data read so that the core can refill its data register from the next address. An instruction write that arrives while the core reports busy is dropped. In 4-bit mode only the upper four data lines are used. Each byte then moves as two transfers, high half first. The block also drives the output-enable of the three-state data bus.

Top module: `lcd_host_if`

## Requirements
- R1: A write with register-select 0 produces one `ir_wr` pulse, and `wr_byte` carries the written byte. `wr_byte` changes only together with a write strobe.
- R2: A write with register-select 1 produces one `dr_wr` pulse carrying the byte. A read with register-select 1 returns `core_rdata` on `bus_d_out`. Core busy has no effect on either.
- R3: A read with register-select 0 returns status on `bus_d_out`: bit 7 is `core_busy` and bits 6..0 are `core_addr`. No strobe is issued.
- R4: Strobes are one-cycle pulses, at most one at a time. None is issued while enable is high. Each appears within 6 clock cycles after enable falls.
- R5: An instruction write committed while `core_busy` is 1 produces no `ir_wr`, and `wr_byte` keeps its previous value.
- R6: With `nibble_mode`=1, a write takes two transfers. The first carries bits 7..4 and the second bits 3..0, both on data lines 7..4. Lines 3..0 are ignored. The strobe follows only the second transfer.
- R7: With `nibble_mode`=1, a read takes two transfers. The first shows bits 7..4 of the selected byte on lines 7..4, and the second shows bits 3..0 on lines 7..4. Lines 3..0 read as 0. The byte is sampled at the start of the first transfer.
- R8: `bus_d_oe` is 1 only while `bus_en`=1, `bus_rw`=1 and `par_sel`=1. `bus_d_out` is 0 whenever `bus_d_oe` is 0.
- R9: `dr_rd` pulses once after the falling enable that ends a data read (after the second transfer in 4-bit mode). It never follows a status read.
- R10: After reset there are no strobes, `bus_d_oe` is 0 and `wr_byte` is 0. The first 4-bit transfer after reset is the high half.
- R11: With `par_sel`=0, enable pulses produce no strobe and no bus drive. With `nibble_mode`=0, any pending low-half state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| par_sel | input | 1 | 1 = parallel bus is the active host port |
| nibble_mode | input | 1 | 1 = 4-bit transfers on lines 7..4 |
| bus_en | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | Host register-select (asynchronous) |
| bus_rw | input | 1 | Host read (1) / write (0) (asynchronous) |
| bus_d_in | input | 8 | Data lines as seen from the pads |
| bus_d_out | output | 8 | Data driven toward the pads on reads |
| bus_d_oe | output | 1 | Pad output-enable |
| core_busy | input | 1 | Core busy flag |
| core_addr | input | 7 | Core address counter |
| core_rdata | input | 8 | Core data register contents for reads |
| ir_wr | output | 1 | Instruction write strobe |
| dr_wr | output | 1 | Data write strobe |
| dr_rd | output | 1 | Data read-done strobe |
| wr_byte | output | 8 | Byte for the write strobes |

## Verification
A nibble toggle left in the wrong state would show on the very next 4-bit transfer. A read would put the wrong half on lines 7..4, or a write would strobe after one transfer instead of two. A transfer kind latched wrongly would issue the wrong strobe, or a status byte in place of data, within a few cycles of the falling enable. A missed busy check would show as an `ir_wr` pulse during a transfer that should have been dropped. A snapshot taken at the wrong moment would make the two halves of one 4-bit read disagree with a single byte.

// File: rtl/lcd_hif_pkg.sv
package lcd_hif_pkg;

  typedef enum logic [1:0] {
    XK_INSTR_WR  = 2'b00,
    XK_STATUS_RD = 2'b01,
    XK_DATA_WR   = 2'b10,
    XK_DATA_RD   = 2'b11
  } xfer_kind_e;

  function automatic xfer_kind_e classify(input logic rs, input logic rw);
    return xfer_kind_e'({rs, rw});
  endfunction

  function automatic logic kind_is_read(input xfer_kind_e k);
    return k == XK_STATUS_RD || k == XK_DATA_RD;
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic [6:0] addr);
    return {busy, addr};
  endfunction

  function automatic logic [7:0] half_on_upper(input logic [7:0] word, input logic low_half);
    return low_half ? {word[3:0], 4'h0} : {word[7:4], 4'h0};
  endfunction

  function automatic logic [7:0] join_halves(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/lcd_hif_sync.sv
module lcd_hif_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lcd_hif_edge.sv
module lcd_hif_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/lcd_hif_xfer.sv
module lcd_hif_xfer
  import lcd_hif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              en_s,
  input  logic              rs_s,
  input  logic              rw_s,
  input  logic              nibble_mode,
  input  logic [DATA_W-1:0] d_in,
  input  logic              core_busy,
  input  logic [DATA_W-2:0] core_addr,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              lo_pend,
  output logic              ir_wr,
  output logic              dr_wr,
  output logic              dr_rd,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int HALF = DATA_W / 2;

  xfer_kind_e          kind_q;
  logic [DATA_W-1:0]   d_hold;
  logic [DATA_W-1:0]   snap;
  logic [HALF-1:0]     hi_half;
  logic                full_done;
  logic [DATA_W-1:0]   commit_byte;

  assign full_done   = !nibble_mode || lo_pend;
  assign commit_byte = nibble_mode ? join_halves(hi_half, d_hold[DATA_W-1:HALF]) : d_hold;
  assign rd_word     = nibble_mode ? half_on_upper(snap, lo_pend) : snap;

  // Data lines are followed while the synchronised enable is high; the last
  // value seen before the falling edge is the one committed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_hold <= '0;
    else if (en_s) d_hold <= d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= XK_INSTR_WR;
      snap   <= '0;
    end else if (ev_rise) begin
      kind_q <= classify(rs_s, rw_s);
      if (rw_s && (!nibble_mode || !lo_pend))
        snap <= rs_s ? core_rdata : status_byte(core_busy, core_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_pend <= 1'b0;
      hi_half <= '0;
    end else if (!nibble_mode) begin
      lo_pend <= 1'b0;
    end else if (ev_fall) begin
      lo_pend <= ~lo_pend;
      if (!lo_pend && !kind_is_read(kind_q)) hi_half <= d_hold[DATA_W-1:HALF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_wr   <= 1'b0;
      dr_wr   <= 1'b0;
      dr_rd   <= 1'b0;
      wr_byte <= '0;
    end else begin
      ir_wr <= 1'b0;
      dr_wr <= 1'b0;
      dr_rd <= 1'b0;
      if (ev_fall && full_done) begin
        unique case (kind_q)
          XK_INSTR_WR: if (!core_busy) begin
            ir_wr   <= 1'b1;
            wr_byte <= commit_byte;
          end
          XK_DATA_WR: begin
            dr_wr   <= 1'b1;
            wr_byte <= commit_byte;
          end
          XK_DATA_RD:   dr_rd <= 1'b1;
          XK_STATUS_RD: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              nibble_mode,
  input  logic              bus_en,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  input  logic              core_busy,
  input  logic [DATA_W-2:0] core_addr,
  input  logic [DATA_W-1:0] core_rdata,
  output logic              ir_wr,
  output logic              dr_wr,
  output logic              dr_rd,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_raw;
  logic [CTRL_W-1:0] ctrl_s;
  logic              en_s, rs_s, rw_s;
  logic              ev_rise, ev_fall;
  logic              lo_pend;
  logic [DATA_W-1:0] rd_word;

  assign ctrl_raw = {bus_en & par_sel, bus_rs, bus_rw};

  lcd_hif_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  assign {en_s, rs_s, rw_s} = ctrl_s;

  lcd_hif_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(en_s), .rise(ev_rise), .fall(ev_fall)
  );

  lcd_hif_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .ev_rise(ev_rise), .ev_fall(ev_fall), .en_s(en_s),
    .rs_s(rs_s), .rw_s(rw_s), .nibble_mode(nibble_mode), .d_in(bus_d_in),
    .core_busy(core_busy), .core_addr(core_addr), .core_rdata(core_rdata),
    .rd_word(rd_word), .lo_pend(lo_pend), .ir_wr(ir_wr), .dr_wr(dr_wr),
    .dr_rd(dr_rd), .wr_byte(wr_byte)
  );

  // Pad drive follows the raw pins so the bus turns around with the host.
  assign bus_d_oe  = bus_en & bus_rw & par_sel;
  assign bus_d_out = bus_d_oe ? rd_word : '0;
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nibble_mode,
  input logic              core_busy,
  input logic              bus_d_oe,
  input logic [DATA_W-1:0] bus_d_out,
  input logic              ir_wr,
  input logic              dr_wr,
  input logic              dr_rd,
  input logic [DATA_W-1:0] wr_byte,
  input logic              en_s,
  input logic              ev_fall,
  input logic              lo_pend
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_wr, dr_wr, dr_rd})); // R4
  AST_IR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> !ir_wr); // R4
  AST_DW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !dr_wr); // R4
  AST_STROBE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_wr || dr_wr || dr_rd) |-> !$past(en_s)); // R4
  AST_IR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> !$past(core_busy)); // R5
  AST_WRBYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_wr || dr_wr) |-> $stable(wr_byte)); // R1
  AST_DRRD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    dr_rd |-> $past(ev_fall)); // R9
  AST_BYTE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !nibble_mode |=> !lo_pend); // R11
  AST_NIB_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (nibble_mode && bus_d_oe) |-> bus_d_out[3:0] == 4'h0); // R7
endmodule

bind lcd_host_if lcd_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .core_busy(core_busy),
  .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out), .ir_wr(ir_wr), .dr_wr(dr_wr),
  .dr_rd(dr_rd), .wr_byte(wr_byte), .en_s(en_s), .ev_fall(ev_fall), .lo_pend(lo_pend)
);

// File: tb/lcd_host_if_bench.sv
module lcd_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic       clk = 0, rst_n = 0;
  logic       par_sel = 1, nibble_mode = 0;
  logic       bus_en = 0, bus_rs = 0, bus_rw = 0;
  logic [7:0] bus_d_in = 0, bus_d_out, core_rdata = 0, wr_byte;
  logic       bus_d_oe, core_busy = 0, ir_wr, dr_wr, dr_rd;
  logic [6:0] core_addr = 0;

  int checks = 0, errors = 0;
  int n_ir = 0, n_dw = 0, n_dr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_host_if u_lcd_host_if (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .nibble_mode(nibble_mode),
    .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_d_in(bus_d_in),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .core_busy(core_busy),
    .core_addr(core_addr), .core_rdata(core_rdata), .ir_wr(ir_wr), .dr_wr(dr_wr),
    .dr_rd(dr_rd), .wr_byte(wr_byte)
  );

  always @(posedge clk) begin
    if (ir_wr) n_ir <= n_ir + 1;
    if (dr_wr) n_dw <= n_dw + 1;
    if (dr_rd) n_dr <= n_dr + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One enable pulse. Returns bus value and oe sampled while enable is high,
  // and checks that no strobe appears before enable falls.
  task automatic xfer(input logic rs, input logic rw, input logic [7:0] din,
                      output logic [7:0] rd, output logic oe);
    int ir0, dw0, dr0;
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_d_in = din;
    ir0 = n_ir; dw0 = n_dw; dr0 = n_dr;
    repeat (3) @(negedge clk);
    bus_en = 1;
    repeat (8) @(negedge clk);
    rd = bus_d_out; oe = bus_d_oe;
    chk("R4 no strobe while enable high", n_ir + n_dw + n_dr, ir0 + dw0 + dr0);
    bus_en = 0;
    repeat (10) @(negedge clk);
  endtask

  // stimulus table: {rs, rw, din[7:0], busy, addr[6:0], rdata[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h38, 1'b0, 7'h00, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b0, 7'h15, 8'h99},
    {1'b0, 1'b1, 8'h00, 1'b1, 7'h7F, 8'h00},
    {1'b0, 1'b0, 8'h01, 1'b1, 7'h02, 8'h00},
    {1'b1, 1'b0, 8'hA5, 1'b1, 7'h00, 8'h00},
    {1'b1, 1'b1, 8'h00, 1'b0, 7'h44, 8'h5C},
    {1'b1, 1'b0, 8'h00, 1'b0, 7'h00, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b0, 7'h00, 8'hFF}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd, last_wr;
    logic oe;
    int ir0, dw0, dr0;

    repeat (3) @(negedge clk);
    chk("R10 reset oe", bus_d_oe, 0);
    chk("R10 reset wr_byte", wr_byte, 0);
    chk("R10 reset strobes", {ir_wr, dr_wr, dr_rd}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    last_wr = 8'h00;

    for (int i = 0; i < NVEC; i++) begin
      logic rs, rw, busy; logic [7:0] din, rdat; logic [6:0] addr;
      {rs, rw, din, busy, addr, rdat} = VEC[i];
      core_busy = busy; core_addr = addr; core_rdata = rdat;
      ir0 = n_ir; dw0 = n_dw; dr0 = n_dr;
      xfer(rs, rw, din, rd, oe);
      chk("R8 oe during transfer", oe, rw);
      if (rw) begin
        if (rs) chk("R2 data read value", rd, rdat);
        else    chk("R3 status read value", rd, {busy, addr});
        chk("R9 read-done strobes", n_dr - dr0, rs ? 1 : 0);
        chk("R3 no write strobe on read", (n_ir - ir0) + (n_dw - dw0), 0);
      end else if (!rs) begin
        chk("R1 R5 instr strobe count", n_ir - ir0, busy ? 0 : 1);
        if (!busy) last_wr = din;
        chk("R1 R5 wr_byte", wr_byte, last_wr);
      end else begin
        chk("R2 data write strobe", n_dw - dw0, 1);
        last_wr = din;
        chk("R2 data write byte", wr_byte, last_wr);
      end
    end

    // 4-bit instruction write: 0x4_ then 0x_2, low lines garbage
    core_busy = 0;
    nibble_mode = 1;
    repeat (2) @(negedge clk);
    ir0 = n_ir;
    xfer(0, 0, 8'h4B, rd, oe);
    chk("R6 no strobe after first half", n_ir - ir0, 0);
    xfer(0, 0, 8'h2D, rd, oe);
    chk("R6 strobe after second half", n_ir - ir0, 1);
    chk("R6 assembled byte", wr_byte, 8'h42);

    // 4-bit data read of 0xC3
    core_rdata = 8'hC3;
    dr0 = n_dr;
    xfer(1, 1, 8'h00, rd, oe);
    chk("R7 first read half", rd, 8'hC0);
    chk("R9 no read-done after first half", n_dr - dr0, 0);
    core_rdata = 8'h11;
    xfer(1, 1, 8'h00, rd, oe);
    chk("R7 second read half from snapshot", rd, 8'h30);
    chk("R9 read-done after second half", n_dr - dr0, 1);

    // 4-bit status read: busy=1 addr=0x2A -> 0xAA
    core_busy = 1; core_addr = 7'h2A;
    xfer(0, 1, 8'h00, rd, oe);
    chk("R7 R3 status high half", rd, 8'hA0);
    xfer(0, 1, 8'h00, rd, oe);
    chk("R7 R3 status low half", rd, 8'hA0);
    core_busy = 0;

    // leave 4-bit mode with a half pending, then a byte write
    xfer(1, 0, 8'h70, rd, oe);
    nibble_mode = 0;
    repeat (3) @(negedge clk);
    dw0 = n_dw;
    xfer(1, 0, 8'h5A, rd, oe);
    chk("R11 byte write after pending half cleared", wr_byte, 8'h5A);
    chk("R11 single strobe", n_dw - dw0, 1);

    // parallel port deselected: no drive, no strobe
    par_sel = 0;
    ir0 = n_ir; dw0 = n_dw; dr0 = n_dr;
    xfer(1, 1, 8'h00, rd, oe);
    chk("R11 R8 no oe when deselected", oe, 0);
    chk("R8 bus zero when not driven", rd, 0);
    xfer(0, 0, 8'h77, rd, oe);
    chk("R11 no strobes when deselected", (n_ir - ir0) + (n_dw - dw0) + (n_dr - dr0), 0);
    chk("R11 wr_byte unchanged", wr_byte, 8'h5A);
    par_sel = 1;

    // reset mid-pair, then first 4-bit write half is treated as high
    nibble_mode = 1;
    xfer(1, 0, 8'h90, rd, oe);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 wr_byte after reset", wr_byte, 0);
    dw0 = n_dw;
    xfer(1, 0, 8'hE0, rd, oe);
    xfer(1, 0, 8'h60, rd, oe);
    chk("R10 first half after reset is high", wr_byte, 8'hE6);
    chk("R10 one strobe for pair", n_dw - dw0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule